// File: doc/BRIEF.md
# Edge-Selectable External Interrupt Unit

This block watches a single external interrupt pin that runs with no fixed timing relation to the system clock. A programmable polarity bit chooses whether a rising or a falling transition counts as an event. A detected transition sets a sticky pending flag, and the block raises an interrupt request when the flag is set, the source is unmasked and the global interrupt enable is high.

The pin transition is caught by a storage element that the pin clocks directly, so a pulse much narrower than the system clock period is still recorded. The captured event then passes through a synchroniser into the clock domain. Software writes the mask and polarity through a control write strobe. It clears the pending flag by writing a one to the flag bit through a separate flag write strobe. The interrupt controller clears the flag with an acknowledge pulse. The capture clock is the pin folded with the polarity bit, so a change of polarity while the pin is static can record an event. Software therefore masks the source, changes the polarity, clears the flag and unmasks it again.

Top module: `eint_unit`

## Requirements
- R1: With the polarity bit (control write data bit 1) at 0, a falling transition on `pin_i` sets the pending flag within SYNC_STAGES+2 clock cycles.
- R2: With the polarity bit at 1, a rising transition on `pin_i` sets the pending flag within SYNC_STAGES+2 clock cycles.
- R3: `irq_o` is 1 only while `gie_i` is 1, the mask bit (control write data bit 0) is 1 and the pending flag is set. The flag stays set while the request is blocked, and a request appears once the mask and the enable are opened.
- R4: A pin pulse of 2 ns, a quarter of the clock period, in the selected direction sets the pending flag.
- R5: A flag write with data bit 0 at 1 clears the pending flag at the next clock edge. A flag write with that bit at 0 leaves the flag unchanged.
- R6: With the pin high, changing the polarity from 0 to 1 sets the pending flag. The sequence of masking, changing the polarity, clearing the flag and unmasking produces no request at any cycle.
- R7: An `ack_i` pulse clears the pending flag at the clock edge that samples it.
- R8: When a synchronised pin event and a clear (ack or flag write) fall in the same cycle, the flag is set after that edge.
- R9: After reset, mask, polarity and flag are 0 (falling mode, masked, nothing pending), and `irq_o` is 0.
- R10: A transition in the direction that is not selected leaves the pending flag clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | External interrupt pin, asynchronous to clk_i |
| gie_i | input | 1 | Global interrupt enable |
| ctl_we_i | input | 1 | Write strobe for mask (bit 0) and polarity (bit 1) |
| flg_we_i | input | 1 | Write strobe for the flag; data bit 0 at 1 clears the flag |
| wdata_i | input | DATA_W | Write data shared by both strobes |
| ack_i | input | 1 | Interrupt acknowledge, clears the flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The main sweep covers both polarity settings against both transition directions, under all four combinations of global enable and mask. A matching direction must raise the request only when both gates are open. A non-matching direction must raise nothing, even after the gates are opened. After each transition with the request blocked, the bench opens the gates, which separates a flag that was set but masked from one that was never set. Separate patterns use a sub-cycle pulse, a polarity flip with the pin held high, and the full mask-flip-clear-unmask sequence watched every cycle. A pin event is also placed in the same cycle as an acknowledge, which separates clear-wins from set-wins priority.

// File: rtl/eint_pkg.sv
`timescale 1ns/1ps
package eint_pkg;

   typedef struct packed {
      logic pol;   // 1: rising edge selected, 0: falling edge selected
      logic mask;  // 1: source may request
   } eint_cfg_t;

   localparam eint_cfg_t EINT_CFG_RESET = '{pol: 1'b0, mask: 1'b0};

endpackage

// File: rtl/eint_edge_capture.sv
`timescale 1ns/1ps
// Records pin transitions without the system clock: the pin, folded with
// the polarity bit, clocks a toggle flop. Each selected edge flips it.
module eint_edge_capture (
   input  logic rst_ni,
   input  logic pin_i,
   input  logic pol_i,
   output logic tog_o
);

   logic edge_clk;
   logic tog_q;

   // pol=1 -> pin itself; pol=0 -> inverted pin. A rising edge_clk is an event.
   assign edge_clk = ~(pin_i ^ pol_i);

   always_ff @(posedge edge_clk or negedge rst_ni) begin
      if (!rst_ni) tog_q <= 1'b0;
      else         tog_q <= ~tog_q;
   end

   assign tog_o = tog_q;

endmodule

// File: rtl/eint_sync.sv
`timescale 1ns/1ps
// Brings the capture toggle into the clock domain and turns each change
// of the synchronised level into a single-cycle event.
module eint_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic async_i,
   output logic evt_o
);

   localparam int unsigned LAST = STAGES - 1;

   logic [LAST:0] stage_q;
   logic          prev_q;

   generate
      genvar gi;
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) stage_q[gi] <= 1'b0;
               else         stage_q[gi] <= async_i;
            end
         end else begin : g_next
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) stage_q[gi] <= 1'b0;
               else         stage_q[gi] <= stage_q[gi-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b0;
      else         prev_q <= stage_q[LAST];
   end

   assign evt_o = stage_q[LAST] ^ prev_q;

endmodule

// File: rtl/eint_flag_ctl.sv
`timescale 1ns/1ps
module eint_flag_ctl
   import eint_pkg::*;
#(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned MASK_BIT = 0,
   parameter int unsigned POL_BIT  = 1,
   parameter int unsigned FLAG_BIT = 0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              ctl_we_i,
   input  logic              flg_we_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              ack_i,
   input  logic              edge_evt_i,
   output eint_cfg_t         cfg_o,
   output logic              flag_o
);

   eint_cfg_t cfg_q;
   logic      flag_q;
   logic      flag_clr;
   logic      flag_nxt;

   assign flag_clr = (flg_we_i & wdata_i[FLAG_BIT]) | ack_i;
   // a fresh event takes priority over any clear in the same cycle
   assign flag_nxt = edge_evt_i | (flag_q & ~flag_clr);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cfg_q  <= EINT_CFG_RESET;
         flag_q <= 1'b0;
      end else begin
         if (ctl_we_i) begin
            cfg_q.mask <= wdata_i[MASK_BIT];
            cfg_q.pol  <= wdata_i[POL_BIT];
         end
         flag_q <= flag_nxt;
      end
   end

   assign cfg_o  = cfg_q;
   assign flag_o = flag_q;

endmodule

// File: rtl/eint_unit.sv
`timescale 1ns/1ps
module eint_unit
   import eint_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned MASK_BIT    = 0,
   parameter int unsigned POL_BIT     = 1,
   parameter int unsigned FLAG_BIT    = 0,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              pin_i,
   input  logic              gie_i,
   input  logic              ctl_we_i,
   input  logic              flg_we_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              ack_i,
   output logic              irq_o
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("eint_unit: SYNC_STAGES must be at least 2");
      end
      if (MASK_BIT >= DATA_W || POL_BIT >= DATA_W || FLAG_BIT >= DATA_W) begin : g_bad_bit
         $error("eint_unit: field bit outside write data");
      end
      if (MASK_BIT == POL_BIT) begin : g_bad_overlap
         $error("eint_unit: mask and polarity share a bit");
      end
   endgenerate

   eint_cfg_t cfg;
   logic      tog;
   logic      edge_evt;
   logic      flag_q;

   eint_edge_capture u_cap (
      .rst_ni (rst_ni),
      .pin_i  (pin_i),
      .pol_i  (cfg.pol),
      .tog_o  (tog)
   );

   eint_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (tog),
      .evt_o   (edge_evt)
   );

   eint_flag_ctl #(
      .DATA_W   (DATA_W),
      .MASK_BIT (MASK_BIT),
      .POL_BIT  (POL_BIT),
      .FLAG_BIT (FLAG_BIT)
   ) u_flag (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ctl_we_i   (ctl_we_i),
      .flg_we_i   (flg_we_i),
      .wdata_i    (wdata_i),
      .ack_i      (ack_i),
      .edge_evt_i (edge_evt),
      .cfg_o      (cfg),
      .flag_o     (flag_q)
   );

   assign irq_o = gie_i & cfg.mask & flag_q;

endmodule

// File: rtl/eint_unit_chk.sv
`timescale 1ns/1ps
module eint_unit_chk #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned MASK_BIT = 0,
   parameter int unsigned FLAG_BIT = 0
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              ctl_we_i,
   input logic              flg_we_i,
   input logic [DATA_W-1:0] wdata_i,
   input logic              ack_i,
   input logic              irq_o,
   input logic              edge_evt,
   input logic              flag_q
);

   AST_MASK_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctl_we_i && !wdata_i[MASK_BIT]) |=> !irq_o); // R3

   AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flg_we_i && wdata_i[FLAG_BIT] && !edge_evt) |=> !flag_q); // R5

   AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q && !ack_i && !(flg_we_i && wdata_i[FLAG_BIT])) |=> flag_q); // R5

   AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i && !edge_evt) |=> !flag_q); // R7

   AST_EVENT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      edge_evt |=> flag_q); // R8

   AST_NO_SPURIOUS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!flag_q && !edge_evt) |=> !flag_q); // R10

endmodule

bind eint_unit eint_unit_chk #(
   .DATA_W   (DATA_W),
   .MASK_BIT (MASK_BIT),
   .FLAG_BIT (FLAG_BIT)
) u_chk (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .ctl_we_i (ctl_we_i),
   .flg_we_i (flg_we_i),
   .wdata_i  (wdata_i),
   .ack_i    (ack_i),
   .irq_o    (irq_o),
   .edge_evt (edge_evt),
   .flag_q   (flag_q)
);

// File: tb/eint_unit_tb_top.sv
`timescale 1ns/1ps
module eint_unit_tb_top;

   localparam int unsigned DATA_W = 8;
   localparam int unsigned SYNC   = 2;
   localparam int unsigned SETTLE = SYNC + 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              pin = 1'b1;
   logic              gie = 1'b0;
   logic              ctl_we = 1'b0;
   logic              flg_we = 1'b0;
   logic [DATA_W-1:0] wdata = '0;
   logic              ack = 1'b0;
   logic              irq;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   eint_unit #(
      .DATA_W      (DATA_W),
      .SYNC_STAGES (SYNC)
   ) dut_i (
      .clk_i    (clk),
      .rst_ni   (rst_n),
      .pin_i    (pin),
      .gie_i    (gie),
      .ctl_we_i (ctl_we),
      .flg_we_i (flg_we),
      .wdata_i  (wdata),
      .ack_i    (ack),
      .irq_o    (irq)
   );

   task automatic check(input logic act, input logic exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: irq_o=%b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic write_ctl(input logic m, input logic p);
      @(negedge clk);
      ctl_we = 1'b1;
      wdata  = '0;
      wdata[0] = m;
      wdata[1] = p;
      @(negedge clk);
      ctl_we = 1'b0;
      wdata  = '0;
   endtask

   task automatic write_flag(input logic b);
      @(negedge clk);
      flg_we = 1'b1;
      wdata  = '0;
      wdata[0] = b;
      @(negedge clk);
      flg_we = 1'b0;
      wdata  = '0;
   endtask

   initial begin
      #(200000 * 8);
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic seen;
      idle(3);
      rst_n = 1'b1;
      gie   = 1'b1;
      idle(2);
      check(irq, 1'b0, "R9 reset request low");
      write_ctl(1'b1, 1'b0);
      idle(SETTLE);
      check(irq, 1'b0, "R9 flag clear after reset");

      // sweep: polarity x direction x gie x mask
      for (int p = 0; p < 2; p++) begin
         for (int d = 0; d < 2; d++) begin
            for (int g = 0; g < 2; g++) begin
               for (int m = 0; m < 2; m++) begin
                  logic hit;
                  hit = (d == p);
                  gie = 1'b1;
                  pin = (d == 1) ? 1'b0 : 1'b1;
                  write_ctl(1'b1, p[0]);
                  idle(SETTLE);
                  write_flag(1'b1);
                  idle(SETTLE);
                  check(irq, 1'b0, "R5 flag cleared before edge");
                  gie = g[0];
                  write_ctl(m[0], p[0]);
                  @(negedge clk);
                  #1 pin = ~pin;
                  idle(SETTLE);
                  check(irq, g[0] & m[0] & hit,
                        hit ? (p == 0 ? "R1 falling gated" : "R2 rising gated")
                            : "R10 other edge gated");
                  gie = 1'b1;
                  write_ctl(1'b1, p[0]);
                  @(negedge clk);
                  check(irq, hit, hit ? "R3 flag held while blocked" : "R10 other edge ignored");
               end
            end
         end
      end

      // R5 write zero keeps flag
      gie = 1'b1;
      pin = 1'b1;
      write_ctl(1'b1, 1'b0);
      idle(SETTLE);
      write_flag(1'b1);
      idle(SETTLE);
      @(negedge clk); #1 pin = 1'b0;
      idle(SETTLE);
      check(irq, 1'b1, "R1 flag set for write-zero test");
      write_flag(1'b0);
      idle(2);
      check(irq, 1'b1, "R5 write zero no effect");
      write_flag(1'b1);
      check(irq, 1'b0, "R5 write one clears");

      // R4 short pulse, falling mode
      pin = 1'b1;
      idle(SETTLE);
      write_flag(1'b1);
      idle(SETTLE);
      @(negedge clk);
      #1 pin = 1'b0;
      #2 pin = 1'b1;
      idle(SETTLE);
      check(irq, 1'b1, "R4 short pulse captured");

      // R7 ack clears
      @(negedge clk); ack = 1'b1;
      @(negedge clk); ack = 1'b0;
      check(irq, 1'b0, "R7 ack clears flag");

      // R8 event coincides with ack; flag set first
      @(negedge clk); #1 pin = 1'b0;
      idle(SETTLE);
      check(irq, 1'b1, "R8 flag set before collision");
      pin = 1'b1;
      idle(SETTLE);
      @(negedge clk); pin = 1'b0;
      @(posedge clk);
      @(posedge clk);
      #1 ack = 1'b1;
      @(posedge clk);
      #1 ack = 1'b0;
      @(negedge clk);
      check(irq, 1'b1, "R8 event beats ack");
      idle(2);
      check(irq, 1'b1, "R8 flag remains");

      // R6 polarity change with pin high sets flag
      pin = 1'b1;
      write_ctl(1'b1, 1'b0);
      idle(SETTLE);
      write_flag(1'b1);
      idle(SETTLE);
      check(irq, 1'b0, "R6 clear before flip");
      write_ctl(1'b1, 1'b1);
      idle(SETTLE);
      check(irq, 1'b1, "R6 polarity flip sets flag");

      // R6 safe sequence: mask, flip, clear, unmask
      write_ctl(1'b1, 1'b0);
      idle(SETTLE);
      write_flag(1'b1);
      idle(SETTLE);
      seen = 1'b0;
      write_ctl(1'b0, 1'b0);
      seen |= irq;
      write_ctl(1'b0, 1'b1);
      for (int i = 0; i < SETTLE; i++) begin
         @(negedge clk);
         seen |= irq;
      end
      write_flag(1'b1);
      seen |= irq;
      write_ctl(1'b1, 1'b1);
      for (int i = 0; i < SETTLE; i++) begin
         @(negedge clk);
         seen |= irq;
      end
      check(seen, 1'b0, "R6 no request during sequence");

      // R3 gie low blocks an otherwise pending request
      @(negedge clk); #1 pin = 1'b0;
      @(negedge clk); #1 pin = 1'b1;
      idle(SETTLE);
      check(irq, 1'b1, "R2 rising pending");
      gie = 1'b0;
      #1;
      check(irq, 1'b0, "R3 gie low blocks");
      gie = 1'b1;

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule